// File: doc/BRIEF.md
# Phase-Qualified Asynchronous SRAM Controller Port

This block sits between a synchronous controller and an asynchronous static RAM whose data pins form a bus shared by the RAM and an external write-data tristate driver. The controller issues a one-cycle request carrying a read/write flag, an address and write data. The block turns it into pin-level strobes: chip select, write enable, output enable, the address, and the enable for the external driver. Read data is captured and returned with a one-cycle acknowledge.

Each accepted request takes one clock period, called the operation cycle. The address and the write/read enables are registered on the accepting rising edge, so they settle during the high half of the clock. Chip select and the write-driver enable are asserted only during the low half. Address changes happen just after a rising edge, while select is inactive, so they always fall outside the select window. Write enable is already low before select falls, so the RAM never drives the bus during a write. The driver enable is qualified by the same low phase and is raised only for writes, so the RAM and the driver are never on the bus together.

Top module: `sram_phase_if`

## Requirements
- R1: While reset is active and after it is released with no request, ram_cs_n, ram_we_n and ram_oe_n are 1, ram_wdrv_en and rd_ack are 0, and req_ready is 1.
- R2: ram_addr is always driven. It takes the request address on the accepting rising edge and holds it for the whole operation cycle, including every moment the write pulse (ram_cs_n low and ram_we_n low) is active.
- R3: ram_wdrv_en is 1 only during the low clock phase of a write's operation cycle. It is never 1 while the RAM drives the bus (ram_oe_n low, ram_cs_n low, ram_we_n high).
- R4: ram_cs_n is 0 exactly in the low clock phase of an operation cycle, and it is 1 in every high phase.
- R5: For a write, ram_we_n is 0 from the accepting edge to the end of the operation cycle, so it is low before ram_cs_n falls. The RAM location then holds the written word.
- R6: For a read, ram_oe_n is 0 for the operation cycle and ram_we_n stays 1. The bus value is captured on the rising edge that ends the select phase, and rd_ack is 1 for exactly the following cycle with that word on rd_data.
- R7: req_ready is 0 during an operation cycle. A request presented while req_ready is 0 is ignored: it causes no select pulse, no acknowledge and no memory change.
- R8: A write never produces rd_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its low phase is the select window |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Block is idle and will accept a request |
| rd_ack | output | 1 | Read data valid, one cycle |
| rd_data | output | DW | Captured read word |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_addr | output | AW | RAM address, always driven |
| ram_wdata | output | DW | Data for the external write driver |
| ram_wdrv_en | output | 1 | Enable of the external write-data tristate driver |
| ram_rdata | input | DW | Value seen on the shared data bus |

## Verification
The bench's RAM model holds its output for a short time after select rises, as a real part does. A design that captures read data one phase late or one phase early therefore returns a stale or empty word. The model counts any instant where the write driver and the RAM drive together, which catches a driver enable that is not gated by the phase or that is raised on reads. It also counts any address change inside a write pulse, which catches select that spans the rising edge. A request held valid through the operation cycle checks that a busy block ignores it: a block that does not would emit a second select pulse and overwrite the neighbouring location, which a later read exposes.

// File: rtl/sram_if_pkg.sv
package sram_if_pkg;

  // Kind of operation latched for the current operation cycle
  typedef enum logic [1:0] {
    OPK_IDLE  = 2'b00,
    OPK_READ  = 2'b01,
    OPK_WRITE = 2'b10
  } op_kind_e;

  function automatic logic kind_busy(input op_kind_e k);
    return k != OPK_IDLE;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= 1'b1;
        else chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sram_req_stage.sv
module sram_req_stage
  import sram_if_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output op_kind_e      op_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_wdata
);
  op_kind_e      kind_d, kind_q;
  logic [AW-1:0] addr_d, addr_q;
  logic [DW-1:0] wdata_d, wdata_q;
  logic          accept;
  logic          load_en;

  // A request is taken only when no operation cycle is in progress
  assign accept  = req_valid && !kind_busy(kind_q);
  assign load_en = accept;

  always_comb begin
    kind_d  = OPK_IDLE;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (accept) begin
      kind_d  = req_write ? OPK_WRITE : OPK_READ;
      addr_d  = req_addr;
      wdata_d = req_write ? req_wdata : wdata_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OPK_IDLE;
    end else begin
      kind_q <= kind_d;
    end
  end

  // Address and data hold outside operations, so the address pins never float or wander
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign req_ready = !kind_busy(kind_q);
  assign op_kind   = kind_q;
  assign op_addr   = addr_q;
  assign op_wdata  = wdata_q;
endmodule

// File: rtl/sram_pin_gen.sv
module sram_pin_gen
  import sram_if_pkg::*;
(
  input  logic     clk,
  input  op_kind_e op_kind,
  output logic     ram_cs_n,
  output logic     ram_we_n,
  output logic     ram_oe_n,
  output logic     ram_wdrv_en
);
  logic low_phase;
  logic is_wr;
  logic is_rd;

  assign low_phase = !clk;
  assign is_wr     = (op_kind == OPK_WRITE);
  assign is_rd     = (op_kind == OPK_READ);

  // Level enables come straight from the registered operation: they settle in the high phase
  assign ram_we_n = !is_wr;
  assign ram_oe_n = !is_rd;

  // Strobes are qualified by the low clock phase only
  assign ram_cs_n    = !(kind_busy(op_kind) && low_phase);
  assign ram_wdrv_en = is_wr && low_phase;
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture
  import sram_if_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_kind_e      op_kind,
  input  logic [DW-1:0] bus_in,
  output logic          rd_ack,
  output logic [DW-1:0] rd_data
);
  logic          cap_en;
  logic          ack_d, ack_q;
  logic [DW-1:0] data_q;

  // The rising edge closing a read's select phase samples the bus
  assign cap_en = (op_kind == OPK_READ);
  assign ack_d  = cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cap_en) data_q <= bus_in;
  end

  assign rd_ack  = ack_q;
  assign rd_data = data_q;
endmodule

// File: rtl/sram_phase_if.sv
module sram_phase_if
  import sram_if_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rd_ack,
  output logic [DW-1:0] rd_data,
  output logic          ram_cs_n,
  output logic          ram_we_n,
  output logic          ram_oe_n,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_wdrv_en,
  input  logic [DW-1:0] ram_rdata
);
  logic     srst_n;
  op_kind_e op_kind;

  sram_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sram_req_stage #(.AW(AW), .DW(DW)) u_req (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .op_kind   (op_kind),
    .op_addr   (ram_addr),
    .op_wdata  (ram_wdata)
  );

  sram_pin_gen u_pins (
    .clk         (clk),
    .op_kind     (op_kind),
    .ram_cs_n    (ram_cs_n),
    .ram_we_n    (ram_we_n),
    .ram_oe_n    (ram_oe_n),
    .ram_wdrv_en (ram_wdrv_en)
  );

  sram_rd_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst_n   (srst_n),
    .op_kind (op_kind),
    .bus_in  (ram_rdata),
    .rd_ack  (rd_ack),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/sram_phase_if_chk.sv
module sram_phase_if_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rd_ack,
  input logic          ram_cs_n,
  input logic          ram_we_n,
  input logic          ram_oe_n,
  input logic [AW-1:0] ram_addr,
  input logic          ram_wdrv_en
);
  logic [AW-1:0] addr_hi;

  // Address seen in the high phase, compared later against the low phase
  always_ff @(negedge clk) addr_hi <= ram_addr;

  // Sampled at a rising edge, values reflect the low phase just ended
  assert_no_contention_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_wdrv_en && !ram_oe_n && !ram_cs_n && ram_we_n));

  assert_drv_only_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wdrv_en |-> !ram_we_n);

  assert_cs_high_phase_R4: assert property (@(negedge clk) disable iff (!rst_n)
    ram_cs_n && !ram_wdrv_en);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n && !ram_we_n) |-> (ram_addr == addr_hi));

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rd_ack);

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_phase_if sram_phase_if_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rd_ack      (rd_ack),
  .ram_cs_n    (ram_cs_n),
  .ram_we_n    (ram_we_n),
  .ram_oe_n    (ram_oe_n),
  .ram_addr    (ram_addr),
  .ram_wdrv_en (ram_wdrv_en)
);

// File: tb/test_sram_phase_if.sv
`timescale 1ns/1ps
module test_sram_phase_if;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rd_ack;
  logic [DW-1:0] rd_data;
  logic          ram_cs_n, ram_we_n, ram_oe_n, ram_wdrv_en;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;

  int checks = 0;
  int errors = 0;
  int contention_cnt = 0;
  int addr_move_cnt = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_mem [0:(1<<AW)-1];
  logic [DW-1:0] exp_q [$];

  always #4 clk = ~clk;   // 125 MHz

  sram_phase_if #(.AW(AW), .DW(DW)) i_sram_phase_if (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_ack(rd_ack), .rd_data(rd_data),
    .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_wdrv_en(ram_wdrv_en), .ram_rdata(ram_rdata)
  );

  // Behavioural RAM with output hold time and a shared bus
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic          ram_drv;
  logic          ram_drv_h;
  logic [DW-1:0] ram_q;
  assign ram_drv = !ram_oe_n && !ram_cs_n && ram_we_n;
  assign #1 ram_drv_h = ram_drv;
  assign #1 ram_q = mem[ram_addr];
  assign ram_rdata = ram_wdrv_en ? ram_wdata : (ram_drv_h ? ram_q : '0);

  always @(negedge clk) begin
    #2;
    if (!ram_cs_n && !ram_we_n) mem[ram_addr] = ram_rdata;
  end
  always @(*) if (ram_wdrv_en && ram_drv) contention_cnt++;
  always @(ram_addr) if (!ram_cs_n && !ram_we_n) addr_move_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit hold);
    @(negedge clk); #1;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); #2;
    chk(req_ready == 1'b0, "R7 ready low in op cycle", req_ready, 0);
    chk(ram_addr == a, "R2 address at op start", ram_addr, a);
    chk(ram_we_n == !w, "R5 we_n settled before select", ram_we_n, !w);
    chk(ram_cs_n == 1'b1, "R4 select high in high phase", ram_cs_n, 1);
    if (w) exp_mem[a] = d;
    else   exp_q.push_back(exp_mem[a]);
    if (hold) begin
      req_write = 1'b1; req_addr = a ^ 8'h01; req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    @(negedge clk); #2;
    chk(ram_cs_n == 1'b0, "R4 select low in low phase", ram_cs_n, 0);
    chk(ram_wdrv_en == w, "R3 driver enable only for write", ram_wdrv_en, w);
    chk(ram_oe_n == w, "R6 oe_n low only for read", ram_oe_n, w);
    chk(ram_addr == a, "R2 address held in select", ram_addr, a);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (hold) begin
      @(negedge clk); #2;
      chk(ram_cs_n == 1'b1, "R7 busy request ignored", ram_cs_n, 1);
    end
  endtask

  // Monitor: scoreboard pops expected read words
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n && rd_ack) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 ack without pending read", 1, 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R6 read data", rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) begin mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(posedge clk);
    #2;
    chk(ram_cs_n && ram_we_n && ram_oe_n, "R1 strobes idle in reset", {ram_cs_n, ram_we_n, ram_oe_n}, 7);
    chk(!ram_wdrv_en && !rd_ack, "R1 driver and ack off in reset", {ram_wdrv_en, rd_ack}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    @(negedge clk); #2;
    chk(ram_cs_n == 1'b1, "R1 no select when idle", ram_cs_n, 1);

    do_req(1'b1, 8'h00, 8'h11, 1'b0);
    do_req(1'b1, 8'hFF, 8'hA5, 1'b0);
    do_req(1'b1, 8'h3C, 8'h5A, 1'b0);
    do_req(1'b0, 8'h00, 8'h00, 1'b0);
    do_req(1'b0, 8'hFF, 8'h00, 1'b0);
    do_req(1'b0, 8'h3C, 8'h00, 1'b0);
    // read then write then read of the same word
    do_req(1'b1, 8'h3C, 8'h77, 1'b0);
    do_req(1'b0, 8'h3C, 8'h00, 1'b0);
    // busy-time request must not overwrite the neighbour
    do_req(1'b1, 8'h41, 8'h12, 1'b0);
    do_req(1'b1, 8'h40, 8'h99, 1'b1);
    do_req(1'b0, 8'h41, 8'h00, 1'b0);
    do_req(1'b0, 8'h40, 8'h00, 1'b0);
    // pattern sweep
    for (int i = 0; i < 16; i++) do_req(1'b1, 8'(i * 17), 8'(i ^ 8'h5A), 1'b0);
    for (int i = 0; i < 16; i++) do_req(1'b0, 8'(i * 17), 8'h00, 1'b0);
    repeat (3) @(posedge clk);
    #2;
    chk(exp_q.size() == 0, "R6 every read acknowledged", exp_q.size(), 0);
    chk(contention_cnt == 0, "R3 no bus contention", contention_cnt, 0);
    chk(addr_move_cnt == 0, "R2 no address change in write pulse", addr_move_cnt, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule